// File: doc/BRIEF.md
# PWM Audio DAC Modulator

This block turns a stream of 16-bit PCM samples into one pulse-width-modulated output per channel. Samples arrive through a data register that accepts either one mono word, which feeds both channels, or a packed stereo pair. They wait in a small buffer until a shared period counter asks for the next one. A control register chooses the PWM resolution (8 or 10 bits), where the pulse sits within the period (left edge, right edge or centre), how many PWM periods each sample lasts (1 to 512), whether the sample MSB is flipped to map signed data onto offset binary, and a left shift applied before the duty value is taken.

Each sample is loaded only at the start of a PWM period, once the previous sample has run for its full repeat count. If the buffer is empty at that point, the previous duty value is kept and a sticky underrun flag is raised. A DMA engine or a CPU feeds the data register and throttles on the request output. A low-pass filter after the pins recovers the audio. The whole block runs on a single core clock.

Top module: `pwm_audio_dac`

## Requirements
- R1: After reset the control register reads 0x00004008 (8-bit resolution, centre alignment, repeat count 1, MSB flip on, shift 0, output disabled), both PWM outputs are low, underrun is low and sample_req is high.
- R2: Control bit 0 enables modulation. While it is 0 both outputs are low and the counters are held at zero. When it is written to 1, the first cycle after the write starts a period at count 0. When it is written back to 0, the outputs are low and underrun is clear two cycles after the write.
- R3: Control bit 1 selects the period length: 0 gives 256 clocks with the duty value taken from bits 15:8 of the converted sample, and 1 gives 1024 clocks with the duty value taken from bits 15:6.
- R4: Control bits 3:2 place the pulse for duty value v and period P. Code 0 drives the output high on counts 0 to v-1. Code 1 drives it high on counts P-v to P-1. Code 2 drives it high from count (P-v)>>1 for v counts. Code 3 behaves like code 0.
- R5: Control bits 12:4 hold N-1, where N is the number of periods each sample lasts. A new sample is taken only at count 0 of the first period of each group of N.
- R6: When control bit 14 is 1, bit 15 of each sample is inverted before conversion. When it is 0, the sample is used unchanged.
- R7: Control bits 17:15 give a left shift of 0 to 7 applied to the 16-bit sample after the MSB step. Bits shifted past bit 15 are lost.
- R8: A write to offset 0x0 with reg_wide=1 stores bits 15:0 for channel 0 and bits 31:16 for channel 1. With reg_wide=0 it stores bits 15:0 for both channels.
- R9: The sample buffer holds FIFO_DEPTH entries. sample_req is high exactly when the buffer is not full, and a data write to a full buffer is dropped.
- R10: If the buffer is empty when a sample is due, both channels keep their previous duty values and underrun goes high. Underrun stays high while the output is enabled and is also visible in bit 31 of the control register read.
- R11: Control bit 13 is stored and read back at offset 0x4 and has no effect on the outputs. Read bits 30:18 are zero, and a read at offset 0x0 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wide | input | 1 | Data write carries a stereo pair (1) or a mono sample (0) |
| reg_addr | input | 4 | Byte offset: 0x0 sample data, 0x4 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sample_req | output | 1 | Buffer has room for another sample word |
| underrun | output | 1 | Sticky flag: a sample was due while the buffer was empty |
| pwm_out | output | 2 | PWM output, bit 0 channel 0, bit 1 channel 1 |

## Verification
The bench builds the block with its default parameters. A 4-entry buffer fills after four writes, so both the dropped fifth write and an underrun that holds the last duty value can be reached within a few periods. With 8- and 10-bit periods of 256 and 1024 clocks, each configuration can be compared cycle by cycle against a bench model over several whole periods and sample groups. Random configurations cover every alignment code, both resolutions, both coding modes, shifts and repeat counts of 1 to 3, mixed with mono and stereo writes.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
    localparam int SAMPLE_W = 16;
    localparam int NCH      = 2;
    localparam int REP_W    = 9;
    localparam int CTRL_W   = 18;

    typedef enum logic [1:0] {
        ALIGN_LEFT   = 2'd0,
        ALIGN_RIGHT  = 2'd1,
        ALIGN_CENTER = 2'd2,
        ALIGN_SPARE  = 2'd3
    } align_e;

    // Bit positions are part of the register contract (MSB first).
    typedef struct packed {
        logic [2:0]       shift;     // 17:15
        logic             flip_msb;  // 14
        logic             keep_bit;  // 13, stored only
        logic [REP_W-1:0] rep_m1;    // 12:4
        align_e           align;     // 3:2
        logic             hi_res;    // 1
        logic             en;        // 0
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{shift: 3'd0, flip_msb: 1'b1, keep_bit: 1'b0,
                                   rep_m1: '0, align: ALIGN_CENTER,
                                   hi_res: 1'b0, en: 1'b0};
endpackage

// File: rtl/pwmdac_fifo.sv
module pwmdac_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    assign empty = (st_q.lvl == '0);
    assign full  = (st_q.lvl == CW'(DEPTH));
    assign level = st_q.lvl;
    assign dout  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.lvl = st_q.lvl + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwmdac_timer.sv
module pwmdac_timer #(
    parameter int RES_LO = 8,
    parameter int RES_HI = 10,
    parameter int REP_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hi_res,
    input  logic [REP_W-1:0]  rep_m1,
    output logic [RES_HI-1:0] cnt,
    output logic              load,
    output logic              wrap
);
    localparam logic [RES_HI-1:0] TOP_LO = RES_HI'((1 << RES_LO) - 1);
    localparam logic [RES_HI-1:0] TOP_HI = '1;

    typedef struct packed {
        logic [RES_HI-1:0] cnt;
        logic [REP_W-1:0]  rep;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [RES_HI-1:0] top;

    assign top  = hi_res ? TOP_HI : TOP_LO;
    assign cnt  = st_q.cnt;
    assign wrap = en && (st_q.cnt >= top);
    assign load = en && (st_q.cnt == '0) && (st_q.rep == '0);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.rep = (st_q.rep >= rep_m1) ? '0 : st_q.rep + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwmdac_cmp.sv
module pwmdac_cmp
    import pwmdac_pkg::*;
#(
    parameter int RES_LO = 8,
    parameter int RES_HI = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hi_res,
    input  align_e            align,
    input  logic [RES_HI-1:0] cnt,
    input  logic [RES_HI-1:0] duty,
    output logic              pwm
);
    localparam int XW = RES_HI + 1;

    logic [XW-1:0] period, c, v, lo;
    logic hit, pwm_d, pwm_q;

    always_comb begin
        period = hi_res ? XW'(1 << RES_HI) : XW'(1 << RES_LO);
        c      = {1'b0, cnt};
        v      = {1'b0, duty};
        lo     = (period - v) >> 1;
        unique case (align)
            ALIGN_RIGHT:  hit = (c >= period - v);
            ALIGN_CENTER: hit = (c >= lo) && (c < lo + v);
            default:      hit = (c < v);
        endcase
        pwm_d = en && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    assign pwm = pwm_q;
endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
    import pwmdac_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int RES_LO     = 8,
    parameter int RES_HI     = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic           reg_wide,
    input  logic [3:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           sample_req,
    output logic           underrun,
    output logic [NCH-1:0] pwm_out
);
    localparam int FW = NCH * SAMPLE_W;
    localparam int LW = $clog2(FIFO_DEPTH + 1);
    localparam logic [3:0] OFS_DATA = 4'h0;
    localparam logic [3:0] OFS_CTRL = 4'h4;

    typedef struct packed {
        ctrl_t                         ctrl;
        logic [NCH-1:0][RES_HI-1:0]    duty;
        logic                          under;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                         en_w, load_w, wrap_w, push_w, pop_w;
    logic                         empty_w, full_w;
    logic [LW-1:0]                level_w;
    logic [FW-1:0]                fifo_din, fifo_dout;
    logic [RES_HI-1:0]            cnt_w;
    logic [NCH-1:0][RES_HI-1:0]   duty_eff;

    function automatic logic [RES_HI-1:0] to_duty(input logic [SAMPLE_W-1:0] s,
                                                  input ctrl_t c);
        logic [SAMPLE_W-1:0] t;
        t = s ^ {c.flip_msb, {(SAMPLE_W-1){1'b0}}};
        t = t << c.shift;
        if (c.hi_res) return t[SAMPLE_W-1 -: RES_HI];
        else          return RES_HI'(t[SAMPLE_W-1 -: RES_LO]);
    endfunction

    assign en_w     = st_q.ctrl.en;
    assign push_w   = reg_we && (reg_addr == OFS_DATA);
    assign fifo_din = reg_wide ? reg_wdata[FW-1:0] : {NCH{reg_wdata[SAMPLE_W-1:0]}};
    assign pop_w    = load_w && !empty_w;

    pwmdac_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push_w), .din(fifo_din), .pop(pop_w),
        .dout(fifo_dout), .empty(empty_w), .full(full_w), .level(level_w)
    );

    pwmdac_timer #(.RES_LO(RES_LO), .RES_HI(RES_HI), .REP_W(REP_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .en(en_w), .hi_res(st_q.ctrl.hi_res),
        .rep_m1(st_q.ctrl.rep_m1), .cnt(cnt_w), .load(load_w), .wrap(wrap_w)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we && (reg_addr == OFS_CTRL)) begin
            st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
        for (int ch = 0; ch < NCH; ch++) begin
            duty_eff[ch] = pop_w ? to_duty(fifo_dout[ch*SAMPLE_W +: SAMPLE_W], st_q.ctrl)
                                 : st_q.duty[ch];
        end
        st_d.duty  = duty_eff;
        st_d.under = en_w && (st_q.under || (load_w && empty_w));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RST;
            st_q.duty  <= '0;
            st_q.under <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwmdac_cmp #(.RES_LO(RES_LO), .RES_HI(RES_HI)) cmp_i (
            .clk(clk), .rst_n(rst_n), .en(en_w), .hi_res(st_q.ctrl.hi_res),
            .align(st_q.ctrl.align), .cnt(cnt_w), .duty(duty_eff[g]),
            .pwm(pwm_out[g])
        );
    end

    assign reg_rdata  = (reg_addr == OFS_CTRL)
                      ? {st_q.under, {(31 - CTRL_W){1'b0}}, st_q.ctrl} : '0;
    assign sample_req = !full_w;
    assign underrun   = st_q.under;
endmodule

// File: rtl/pwm_audio_dac_chk.sv
module pwm_audio_dac_chk #(
    parameter int FIFO_DEPTH = 4,
    parameter int RES_HI     = 10,
    parameter int NCH        = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          en,
    input logic                          load,
    input logic                          wrap,
    input logic                          push,
    input logic                          pop,
    input logic                          fifo_empty,
    input logic                          fifo_full,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    input logic [RES_HI-1:0]             cnt,
    input logic [RES_HI-1:0]             duty0,
    input logic                          underrun,
    input logic [NCH-1:0]                pwm_out
);
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pwm_out == '0)); // R2

    AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && push && !pop) |=> $stable(fifo_level)); // R9

    AST_HOLD_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (load && fifo_empty) |=> $stable(duty0)); // R10

    AST_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && fifo_empty) |=> underrun); // R10

    AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && en) |=> underrun); // R10
endmodule

bind pwm_audio_dac pwm_audio_dac_chk #(
    .FIFO_DEPTH(FIFO_DEPTH), .RES_HI(RES_HI), .NCH(pwmdac_pkg::NCH)
) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .load(load_w), .wrap(wrap_w),
    .push(push_w), .pop(pop_w), .fifo_empty(empty_w), .fifo_full(full_w),
    .fifo_level(level_w), .cnt(cnt_w), .duty0(st_q.duty[0]),
    .underrun(underrun), .pwm_out(pwm_out)
);

// File: tb/pwm_audio_dac_tb_top.sv
module pwm_audio_dac_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_wide = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sample_req, underrun;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] q[$];
    int held[2] = '{0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_audio_dac dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sample_req(sample_req), .underrun(underrun), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic wide);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = wide;
        if (a == 4'h0 && q.size() < DEPTH) q.push_back(wide ? d : {d[15:0], d[15:0]});
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic int duty_of(input logic [15:0] s, input logic [17:0] c);
        logic [15:0] t;
        t = s ^ {c[14], 15'b0};
        t = t << c[17:15];
        return c[1] ? int'(t[15:6]) : int'(t[15:8]);
    endfunction

    function automatic bit exp_bit(input int c, input int v, input int p, input int al);
        int lo;
        lo = (p - v) / 2;
        case (al)
            1: return c >= p - v;
            2: return (c >= lo) && (c < lo + v);
            default: return c < v;
        endcase
    endfunction

    task automatic model_load(input logic [17:0] cfg, inout bit u);
        logic [31:0] w;
        if (q.size() > 0) begin
            w = q.pop_front();
            held[0] = duty_of(w[15:0], cfg);
            held[1] = duty_of(w[31:16], cfg);
        end else u = 1'b1;
    endtask

    task automatic run(input logic [17:0] cfg, input int periods, input string tag);
        int p, n;
        bit u, dummy;
        p = cfg[1] ? 1024 : 256;
        n = int'(cfg[12:4]) + 1;
        u = 0;
        wr(4'h4, {14'b0, cfg | 18'h1}, 1'b0);
        for (int k = 0; k < periods; k++) begin
            int bad[2];
            int fa[2];
            int fe[2];
            int fc[2];
            bad = '{0, 0};
            for (int c = 0; c < p; c++) begin
                if (c == 0 && (k % n) == 0) model_load(cfg, u);
                @(negedge clk);
                for (int ch = 0; ch < 2; ch++) begin
                    bit e;
                    e = exp_bit(c, held[ch], p, int'(cfg[3:2]));
                    if (pwm_out[ch] !== e && bad[ch] == 0) begin
                        fa[ch] = int'(pwm_out[ch]); fe[ch] = int'(e); fc[ch] = c;
                        bad[ch] = 1;
                    end
                end
            end
            for (int ch = 0; ch < 2; ch++) begin
                n_chk++;
                if (bad[ch] != 0) begin
                    n_bad++;
                    $display("FAIL %s ch%0d period %0d count %0d: actual %0d expected %0d",
                             tag, ch, k, fc[ch], fa[ch], fe[ch]);
                end
            end
        end
        chk({tag, " R10 underrun port"}, {31'b0, underrun}, {31'b0, u});
        reg_addr = 4'h4;
        #1;
        chk({tag, " R10 underrun read bit31"}, {31'b0, reg_rdata[31]}, {31'b0, u});
        // The write below lands one cycle into the next period.
        dummy = 0;
        if ((periods % n) == 0) model_load(cfg, dummy);
        wr(4'h4, {14'b0, cfg & ~18'h1}, 1'b0);
        @(negedge clk);
        chk({tag, " R2 outputs low after disable"}, {30'b0, pwm_out}, 32'h0);
        chk({tag, " R2 underrun cleared by disable"}, {31'b0, underrun}, 32'h0);
    endtask

    function automatic logic [17:0] mk(input int sh, input int flip, input int b13,
                                       input int rep_m1, input int al, input int hr);
        return {3'(sh), 1'(flip), 1'(b13), 9'(rep_m1), 2'(al), 1'(hr), 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_addr = 4'h4; #1;
        chk("R1 ctrl reset value", reg_rdata, 32'h0000_4008);
        chk("R1 outputs low", {30'b0, pwm_out}, 32'h0);
        chk("R1 underrun low", {31'b0, underrun}, 32'h0);
        chk("R1 sample_req high", {31'b0, sample_req}, 32'h1);
        reg_addr = 4'h0; #1;
        chk("R11 data offset reads zero", reg_rdata, 32'h0);
        @(negedge clk);

        // R4 alignments, R6 MSB flip, R8 mono writes
        wr(4'h0, 32'h0000_1234, 1'b0); wr(4'h0, 32'h0000_C000, 1'b0);
        wr(4'h0, 32'h0000_7F00, 1'b0);
        run(mk(0, 1, 0, 0, 0, 0), 3, "R4 left R6 flip R8 mono");
        wr(4'h0, 32'h0000_0000, 1'b0); wr(4'h0, 32'h0000_A5A5, 1'b0);
        wr(4'h0, 32'h0000_8001, 1'b0);
        run(mk(0, 1, 0, 0, 1, 0), 3, "R4 right");
        wr(4'h0, 32'h0000_4000, 1'b0); wr(4'h0, 32'h0000_FFFF, 1'b0);
        wr(4'h0, 32'h0000_0333, 1'b0);
        run(mk(0, 1, 0, 0, 2, 0), 3, "R4 center");
        wr(4'h0, 32'h0000_2222, 1'b0); wr(4'h0, 32'h0000_9999, 1'b0);
        run(mk(0, 1, 0, 0, 3, 0), 2, "R4 code3 as left");

        // R3 10-bit with R8 stereo pairs
        wr(4'h0, 32'h1234_F00D, 1'b1); wr(4'h0, 32'h8000_7FFF, 1'b1);
        run(mk(0, 1, 0, 0, 2, 1), 2, "R3 10-bit R8 stereo");

        // R5 repeat count 3
        wr(4'h0, 32'h3000_5000, 1'b1); wr(4'h0, 32'hE000_0100, 1'b1);
        run(mk(0, 1, 0, 2, 0, 0), 6, "R5 repeat 3");

        // R6 unsigned, R7 shift, R11 spare bit
        wr(4'h0, 32'h0F21_1F80, 1'b1); wr(4'h0, 32'h00FF_0A0A, 1'b1);
        run(mk(3, 0, 1, 0, 1, 0), 2, "R6 unsigned R7 shift3 R11 spare");
        reg_addr = 4'h4; #1;
        chk("R11 spare bit read back", reg_rdata, {14'b0, mk(3, 0, 1, 0, 1, 0)});
        @(negedge clk);

        // R10 underrun holds previous value
        wr(4'h0, 32'h0000_6000, 1'b0);
        run(mk(0, 1, 0, 0, 0, 0), q.size() + 2, "R10 hold on empty");

        // R9 full buffer drops write
        for (int i = 0; i < DEPTH; i++) wr(4'h0, 32'h1111_1000 * (i + 1), 1'b1);
        chk("R9 sample_req low when full", {31'b0, sample_req}, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF, 1'b1);
        run(mk(0, 1, 0, 0, 0, 0), DEPTH + 2, "R9 dropped write R10");
        chk("R9 sample_req high after drain", {31'b0, sample_req}, 32'h1);

        // Random configurations
        for (int r = 0; r < 8; r++) begin
            logic [17:0] cfg;
            cfg = mk($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 1));
            for (int i = 0; i < 3; i++) wr(4'h0, $urandom, 1'($urandom_range(0, 1)));
            run(cfg, cfg[1] ? 2 : 3, "R3 R4 R5 R6 R7 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule